// File: doc/BRIEF.md
# I/O Impedance Calibration Sequencer

This block runs the one-time voltage/temperature/process impedance calibration of a DDR I/O bank after reset. A host pulses `start_i`. The sequencer then drives the control bits of an analog calibration macro in a fixed order. First it wakes the macro and unlocks it. Next it applies a high–low–high strobe, where each hold lasts a programmable number of clocks. It then waits for the macro's ready flag, which arrives asynchronously and passes through a two-flop synchronizer. When ready is seen, the sequencer freezes the result by locking and puts the calibration logic back into power-down. Finally it lets idle input receivers power down.

A single completion flag reports success. A timeout flag reports that ready never came within a programmable window. In that case the macro is left unlocked and awake. Both flags hold until the next start. The hold length and the timeout window are captured when a run begins. The macro and any register programming around it are outside this block.

Top module: `iocal_seq`

## Requirements
- R1: While and after reset, before any start: `cal_pwrdn_o`=1, `cal_lock_o`=1, `cal_strobe_o`=0, and `rx_pwrdn_en_o`, `busy_o`, `done_o`, `timeout_o` are all 0.
- R2: A start pulse sampled at clock edge E0 while not busy has these effects, all visible after E0:
  - `cal_pwrdn_o` goes to 0, `busy_o` goes to 1, and `cal_strobe_o` is held at 0;
  - `done_o`, `timeout_o` and `rx_pwrdn_en_o` are cleared;
  - `hold_cycles_i` and `timeout_i` are captured.
- R3: `cal_lock_o` goes to 0 after edge E0+1, and the strobe stays low until then.
- R4: Let Hc = max(hold_cycles, 1). `cal_strobe_o` rises after E0+2 and stays high for Hc cycles. It is then low for Hc cycles, rises after E0+2+2·Hc, and stays high.
- R5: `ready_i` goes through a two-flop synchronizer and is only acted on during the wait phase. If `ready_i` is 1 before edge E0+3+2·Hc+D, then `cal_lock_o` rises after edge E0+5+2·Hc+D.
- R6: Let Tc = max(timeout, 1). If synchronized ready has not been seen by the Tc-th edge of the wait phase (edge E0+2+2·Hc+Tc), `timeout_o` rises after that edge and `busy_o` falls. Lock stays 0, power-down stays 0 and the strobe stays 1. Ready on that same edge still wins.
- R7: One cycle after lock rises, `cal_pwrdn_o` rises. One cycle after that, `rx_pwrdn_en_o` and `done_o` rise and `busy_o` falls.
- R8: `done_o` and `timeout_o` hold their value until the next accepted start.
- R9: A start pulse while `busy_o`=1 has no effect on any output.
- R10: Changes to `hold_cycles_i` or `timeout_i` after the start edge have no effect on the running sequence.
- R11: At most one of `busy_o`, `done_o` and `timeout_o` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Calibration clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| hold_cycles_i | input | HOLD_W | Strobe hold length in cycles (0 acts as 1) |
| timeout_i | input | TMO_W | Ready wait window in cycles (0 acts as 1) |
| ready_i | input | 1 | Asynchronous ready flag from the macro |
| cal_pwrdn_o | output | 1 | Calibration macro power-down |
| cal_lock_o | output | 1 | Calibration result lock |
| cal_strobe_o | output | 1 | Calibration clock/reset strobe |
| rx_pwrdn_en_o | output | 1 | Idle input receiver power-down enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Calibration completed and locked |
| timeout_o | output | 1 | Ready not seen within window |

## Verification
The assertions check the ordering rules on every cycle:
- lock may fall only while the macro is awake;
- a strobe rise requires the macro to be unlocked and awake;
- lock may rise only on a synchronized ready;
- power-down may come back only while locked;
- a timeout excludes lock and done;
- the three status flags are mutually exclusive.

The exact cycle positions need the bench's scenarios: hold lengths, the three-edge ready latency, and the tie between ready and the last timeout edge. So do the effects of a start pulse or input changes during a run, and the state left behind after a failed run.

// File: rtl/iocal_pkg.sv
package iocal_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNLK,
    ST_ARM,
    ST_HI,
    ST_LO,
    ST_WAIT,
    ST_PDON,
    ST_RXPD,
    ST_DONE,
    ST_ERR
  } iocal_state_e;
endpackage

// File: rtl/iocal_sync.sv
module iocal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/iocal_timer.sv
module iocal_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (dec_i) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q <= W'(1));
endmodule

// File: rtl/iocal_fsm.sv
module iocal_fsm
  import iocal_pkg::*;
#(
  parameter int HOLD_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic              rdy_s_i,
  input  logic              hold_last_i,
  input  logic              wait_last_i,
  output logic              hold_ld_o,
  output logic              hold_dec_o,
  output logic [HOLD_W-1:0] hold_val_o,
  output logic              wait_ld_o,
  output logic              wait_dec_o,
  output logic [TMO_W-1:0]  wait_val_o,
  output logic              pwrdn_o,
  output logic              lock_o,
  output logic              strobe_o,
  output logic              rxpd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              tmo_o
);
  iocal_state_e      state_q;
  logic [HOLD_W-1:0] hold_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              idle_like;

  assign idle_like  = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERR);
  assign hold_val_o = (hold_q == '0) ? HOLD_W'(1) : hold_q;
  assign wait_val_o = (tmo_q == '0) ? TMO_W'(1) : tmo_q;

  always_comb begin
    hold_ld_o  = (state_q == ST_ARM) || ((state_q == ST_HI) && hold_last_i);
    hold_dec_o = ((state_q == ST_HI) || (state_q == ST_LO)) && !hold_last_i;
    wait_ld_o  = (state_q == ST_LO) && hold_last_i;
    wait_dec_o = (state_q == ST_WAIT) && !rdy_s_i && !wait_last_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      hold_q   <= '0;
      tmo_q    <= '0;
      pwrdn_o  <= 1'b1;
      lock_o   <= 1'b1;
      strobe_o <= 1'b0;
      rxpd_o   <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      tmo_o    <= 1'b0;
    end else begin
      case (state_q)
        ST_UNLK: begin
          lock_o  <= 1'b0;
          state_q <= ST_ARM;
        end
        ST_ARM: begin
          strobe_o <= 1'b1;
          state_q  <= ST_HI;
        end
        ST_HI: begin
          if (hold_last_i) begin
            strobe_o <= 1'b0;
            state_q  <= ST_LO;
          end
        end
        ST_LO: begin
          if (hold_last_i) begin
            strobe_o <= 1'b1;
            state_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rdy_s_i) begin
            lock_o  <= 1'b1;
            state_q <= ST_PDON;
          end else if (wait_last_i) begin
            tmo_o   <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_ERR;
          end
        end
        ST_PDON: begin
          pwrdn_o <= 1'b1;
          state_q <= ST_RXPD;
        end
        ST_RXPD: begin
          rxpd_o  <= 1'b1;
          done_o  <= 1'b1;
          busy_o  <= 1'b0;
          state_q <= ST_DONE;
        end
        default: begin
          if (idle_like && start_i) begin
            pwrdn_o  <= 1'b0;
            strobe_o <= 1'b0;
            rxpd_o   <= 1'b0;
            done_o   <= 1'b0;
            tmo_o    <= 1'b0;
            busy_o   <= 1'b1;
            hold_q   <= hold_cycles_i;
            tmo_q    <= timeout_i;
            state_q  <= ST_UNLK;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/iocal_seq.sv
module iocal_seq #(
  parameter int HOLD_W      = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic              ready_i,
  output logic              cal_pwrdn_o,
  output logic              cal_lock_o,
  output logic              cal_strobe_o,
  output logic              rx_pwrdn_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  logic              rdy_s;
  logic              hold_ld, hold_dec, hold_last;
  logic              wait_ld, wait_dec, wait_last;
  logic [HOLD_W-1:0] hold_val;
  logic [TMO_W-1:0]  wait_val;

  iocal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ready_i),
    .q_o (rdy_s)
  );

  iocal_timer #(.W(HOLD_W)) u_hold_tmr (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (hold_ld),
    .ld_val_i (hold_val),
    .dec_i    (hold_dec),
    .last_o   (hold_last)
  );

  iocal_timer #(.W(TMO_W)) u_wait_tmr (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (wait_ld),
    .ld_val_i (wait_val),
    .dec_i    (wait_dec),
    .last_o   (wait_last)
  );

  iocal_fsm #(.HOLD_W(HOLD_W), .TMO_W(TMO_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .hold_cycles_i (hold_cycles_i),
    .timeout_i     (timeout_i),
    .rdy_s_i       (rdy_s),
    .hold_last_i   (hold_last),
    .wait_last_i   (wait_last),
    .hold_ld_o     (hold_ld),
    .hold_dec_o    (hold_dec),
    .hold_val_o    (hold_val),
    .wait_ld_o     (wait_ld),
    .wait_dec_o    (wait_dec),
    .wait_val_o    (wait_val),
    .pwrdn_o       (cal_pwrdn_o),
    .lock_o        (cal_lock_o),
    .strobe_o      (cal_strobe_o),
    .rxpd_o        (rx_pwrdn_en_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .tmo_o         (timeout_o)
  );
endmodule

// File: rtl/iocal_seq_chk.sv
module iocal_seq_chk (
  input logic clk,
  input logic rst,
  input logic rdy_s,
  input logic cal_pwrdn_o,
  input logic cal_lock_o,
  input logic cal_strobe_o,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o
);
  // R3
  unlock_awake_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_lock_o) |-> !cal_pwrdn_o);

  // R4
  strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_strobe_o) |-> (!cal_lock_o && !cal_pwrdn_o));

  // R5
  lock_on_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_lock_o) |-> $past(rdy_s));

  // R7
  sleep_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_pwrdn_o) |-> cal_lock_o);

  // R6
  timeout_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (!cal_lock_o && !done_o));

  // R11
  status_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_o, done_o, timeout_o}));

  // R9
  busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o || timeout_o));
endmodule

bind iocal_seq iocal_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .rdy_s        (rdy_s),
  .cal_pwrdn_o  (cal_pwrdn_o),
  .cal_lock_o   (cal_lock_o),
  .cal_strobe_o (cal_strobe_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .timeout_o    (timeout_o)
);

// File: tb/iocal_seq_bench.sv
module iocal_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_W = 8;
  localparam int TMO_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [HOLD_W-1:0] hold_cycles_i = '0;
  logic [TMO_W-1:0]  timeout_i = '0;
  logic ready_i = 1'b0;
  logic cal_pwrdn_o, cal_lock_o, cal_strobe_o, rx_pwrdn_en_o;
  logic busy_o, done_o, timeout_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  logic prev_lock = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iocal_seq #(.HOLD_W(HOLD_W), .TMO_W(TMO_W)) u_iocal_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .hold_cycles_i(hold_cycles_i), .timeout_i(timeout_i), .ready_i(ready_i),
    .cal_pwrdn_o(cal_pwrdn_o), .cal_lock_o(cal_lock_o), .cal_strobe_o(cal_strobe_o),
    .rx_pwrdn_en_o(rx_pwrdn_en_o), .busy_o(busy_o), .done_o(done_o),
    .timeout_o(timeout_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  // bit order: pwrdn, lock, strobe, rxpd, busy, done, timeout
  function automatic logic [6:0] exp_vec(input int rel, input int h, input int t,
                                         input int d, input logic plock);
    int hc, tc, tl, te;
    logic ok, pd, lk, st, rx, bz, dn, to;
    hc = (h < 1) ? 1 : h;
    tc = (t < 1) ? 1 : t;
    ok = (3 + d <= tc);
    tl = 5 + 2*hc + d;
    te = 2 + 2*hc + tc;
    pd = ok && (rel >= tl + 1);
    lk = (rel == 0) ? plock : (ok && (rel >= tl));
    st = ((rel >= 2) && (rel < 2 + hc)) || (rel >= 2 + 2*hc);
    rx = ok && (rel >= tl + 2);
    dn = rx;
    to = !ok && (rel >= te);
    bz = ok ? (rel < tl + 2) : (rel < te);
    return {pd, lk, st, rx, bz, dn, to};
  endfunction

  task automatic cmp_vec(input logic [6:0] e);
    chk("R2", "cal_pwrdn_o", cal_pwrdn_o, e[6]);
    chk("R3", "cal_lock_o", cal_lock_o, e[5]);
    chk("R4", "cal_strobe_o", cal_strobe_o, e[4]);
    chk("R7", "rx_pwrdn_en_o", rx_pwrdn_en_o, e[3]);
    chk("R6", "busy_o", busy_o, e[2]);
    chk("R8", "done_o", done_o, e[1]);
    chk("R6", "timeout_o", timeout_o, e[0]);
  endtask

  // One run: h, t, ready delay d; noise injects a busy start (R9) and input changes (R10)
  task automatic run(input int h, input int t, input int d, input bit noise);
    int hc, tc, last, e0;
    logic [6:0] e;
    hc = (h < 1) ? 1 : h;
    tc = (t < 1) ? 1 : t;
    last = ((3 + d <= tc) ? (7 + 2*hc + d) : (2 + 2*hc + tc)) + 4;
    @(negedge clk);
    hold_cycles_i = HOLD_W'(h);
    timeout_i = TMO_W'(t);
    ready_i = 1'b0;
    start_i = 1'b1;
    e0 = cyc + 1;
    for (int rel = 0; rel <= last; rel++) begin
      @(negedge clk);
      if (cyc - e0 != rel) begin
        n_chk++; n_err++;
        $display("FAIL R2 cycle alignment: actual %0d expected %0d", cyc - e0, rel);
      end
      e = exp_vec(rel, h, t, d, prev_lock);
      cmp_vec(e);
      start_i = 1'b0;
      if (noise && rel == 1) begin
        hold_cycles_i = HOLD_W'($urandom_range(0, 9)); // R10
        timeout_i = TMO_W'($urandom_range(0, 20));
      end
      if (noise && rel == 3) start_i = 1'b1;          // R9
      if (rel == 2 + 2*hc + d) ready_i = 1'b1;        // R5
    end
    prev_lock = e[5];
    repeat (3) begin
      @(negedge clk);
      cmp_vec(e);                                     // R8 flags hold
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) begin
      @(negedge clk);
      cmp_vec({1'b1, 1'b1, 5'b0});                    // R1 during reset
    end
    rst = 1'b0;
    repeat (2) begin
      @(negedge clk);
      cmp_vec({1'b1, 1'b1, 5'b0});                    // R1 after reset
    end
    // directed corners
    run(0, 0, 0, 1'b0);   // R4 hold 0 acts as 1, R6 window 1 times out
    run(1, 3, 0, 1'b0);   // R5/R6 ready on the last window edge wins
    run(2, 3, 1, 1'b0);   // R6 one cycle too late, lock stays low
    run(3, 10, 2, 1'b1);  // R9/R10 restart from error state
    run(1, 5, 0, 1'b0);
    run(4, 2, 9, 1'b1);
    for (int i = 0; i < 40; i++) begin
      run(int'($urandom_range(0, 6)), int'($urandom_range(0, 14)),
          int'($urandom_range(0, 12)), 1'($urandom_range(0, 1)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule